// File: doc/BRIEF.md
# Host Cell Receive Mailbox

This block holds one cell that upstream logic has diverted from either traffic direction toward the host processor. The cell arrives as a single parallel capture strobe carrying all of its words together with a direction flag. The block stores the words, writes the direction flag into a fixed bit of one header word, and raises an interrupt status bit.

The host drains the cell through one read port. Each read returns the next stored word, starting at word 0, and an internal pointer advances by one. After the final word has been read, the interrupt status bit drops and the mailbox accepts a new cell. A cell that arrives while the mailbox still holds an undrained cell is discarded, and a sticky overflow flag records the loss.

Top module: `cell_rx_mailbox`

## Requirements
- R1: After reset, `irq_cell`, `ovf_sticky` and `rd_data` are all 0.
- R2: A `cap_valid` pulse while the mailbox is empty stores the cell, and `irq_cell` reads 1 from the next clock edge.
- R3: Each read (`rd_en` high for one cycle) of a full mailbox puts word k on `rd_data` one clock later. Word k is bits [16k+15:16k] of `cap_cell`, and k counts 0, 1, 2 up to 26 over successive reads.
- R4: Bit 6 of stored word 2 is replaced by `cap_upstream` (0 for a downstream cell, 1 for an upstream cell). All other bits are kept as captured.
- R5: `irq_cell` stays 1 through the first 26 reads. It is 0 from the clock edge that registers the 27th read.
- R6: A read while the mailbox is empty returns 0 and does not move the pointer. The next stored cell is still read from word 0.
- R7: A `cap_valid` pulse while the mailbox is full is dropped and leaves the stored cell unchanged. `ovf_sticky` is set and stays 1 until reset.
- R8: A capture in the same cycle as the 27th read is dropped and sets `ovf_sticky`. The mailbox is empty afterwards.
- R9: Once a cell has been fully drained, the next capture is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | One-cycle strobe presenting a diverted cell |
| cap_upstream | input | 1 | Direction of the presented cell: 1 upstream, 0 downstream |
| cap_cell | input | 432 | All 27 words of the cell, word k at bits [16k+15:16k] |
| rd_en | input | 1 | Host read access of the receive register |
| rd_data | output | 16 | Word returned by the most recent read |
| irq_cell | output | 1 | Interrupt status: a cell is waiting |
| ovf_sticky | output | 1 | A cell was dropped since reset |

## Verification
- **Pointer faults:** a read pointer that skips, repeats or fails to wrap shows on the very next `rd_data` as a word from the wrong position. If the pointer fails to wrap, the next cell starts from a nonzero word.
- **Full-state faults:** a wrong full state shows on `irq_cell` at the edge after the read or capture that should have changed it. It also shows as a zero word where data was expected, or as stored data being overwritten by a dropped cell. The overwrite becomes visible on the first read of the following drain.
- **Tag faults:** a misplaced direction tag corrupts word 2 on the third read of the cell.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
   localparam int CMB_WORD_W     = 16;
   localparam int CMB_CELL_WORDS = 27;
   localparam int CMB_TAG_WORD   = 2;
   localparam int CMB_TAG_BIT    = 6;

   typedef enum logic {
      MB_EMPTY = 1'b0,
      MB_FULL  = 1'b1
   } mb_state_t;
endpackage

// File: rtl/cmb_store.sv
module cmb_store #(
   parameter int WORD_W     = cmb_pkg::CMB_WORD_W,
   parameter int CELL_WORDS = cmb_pkg::CMB_CELL_WORDS,
   parameter int TAG_WORD   = cmb_pkg::CMB_TAG_WORD,
   parameter int TAG_BIT    = cmb_pkg::CMB_TAG_BIT,
   localparam int CELL_BITS = WORD_W * CELL_WORDS,
   localparam int PTR_W     = $clog2(CELL_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 upstream,
   input  logic [CELL_BITS-1:0] cell_in,
   input  logic [PTR_W-1:0]     rd_idx,
   output logic [WORD_W-1:0]    word_out
);
   logic [WORD_W-1:0] mem [CELL_WORDS];

   if (TAG_WORD >= CELL_WORDS) begin : g_bad_tag_word
      $error("TAG_WORD outside cell");
   end
   if (TAG_BIT >= WORD_W) begin : g_bad_tag_bit
      $error("TAG_BIT outside word");
   end

   for (genvar i = 0; i < CELL_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] wr_word;
      if (i == TAG_WORD) begin : g_tagged
         always_comb begin
            wr_word          = cell_in[i*WORD_W +: WORD_W];
            wr_word[TAG_BIT] = upstream;
         end
      end else begin : g_plain
         assign wr_word = cell_in[i*WORD_W +: WORD_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (wr_en)
            mem[i] <= wr_word;
      end
   end

   assign word_out = mem[rd_idx];

   // R4
   tag_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[TAG_WORD][TAG_BIT] == $past(upstream));
endmodule

// File: rtl/cmb_ctrl.sv
module cmb_ctrl #(
   parameter int CELL_WORDS = cmb_pkg::CMB_CELL_WORDS,
   localparam int PTR_W     = $clog2(CELL_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_valid,
   input  logic             rd_en,
   output logic             wr_en,
   output logic             full,
   output logic             ovf,
   output logic [PTR_W-1:0] ptr
);
   import cmb_pkg::*;

   localparam logic [PTR_W-1:0] LAST = PTR_W'(CELL_WORDS - 1);

   if (CELL_WORDS < 2) begin : g_bad_cell
      $error("CELL_WORDS must be at least 2");
   end

   mb_state_t        state_q;
   logic [PTR_W-1:0] ptr_q;
   logic             ovf_q;
   logic             rd_hit;
   logic             last_rd;

   assign full    = (state_q == MB_FULL);
   assign rd_hit  = full && rd_en;
   assign last_rd = rd_hit && (ptr_q == LAST);
   assign wr_en   = cap_valid && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MB_EMPTY;
         ptr_q   <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (wr_en)
            state_q <= MB_FULL;
         else if (last_rd)
            state_q <= MB_EMPTY;
         if (rd_hit)
            ptr_q <= last_rd ? '0 : ptr_q + 1'b1;
         if (cap_valid && full)
            ovf_q <= 1'b1;
      end
   end

   assign ptr = ptr_q;
   assign ovf = ovf_q;

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !full) |=> full);
   // R5
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && full && ptr_q == LAST) |=> (!full && ptr_q == '0));
   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && full && ptr_q != LAST) |=> (full && ptr_q == $past(ptr_q) + 1'b1));
   // R6
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !full) |=> $stable(ptr_q));
   // R7
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && full) |=> ovf_q);
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
endmodule

// File: rtl/cell_rx_mailbox.sv
module cell_rx_mailbox #(
   parameter int WORD_W     = cmb_pkg::CMB_WORD_W,
   parameter int CELL_WORDS = cmb_pkg::CMB_CELL_WORDS,
   parameter int TAG_WORD   = cmb_pkg::CMB_TAG_WORD,
   parameter int TAG_BIT    = cmb_pkg::CMB_TAG_BIT,
   localparam int CELL_BITS = WORD_W * CELL_WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_valid,
   input  logic                 cap_upstream,
   input  logic [CELL_BITS-1:0] cap_cell,
   input  logic                 rd_en,
   output logic [WORD_W-1:0]    rd_data,
   output logic                 irq_cell,
   output logic                 ovf_sticky
);
   localparam int PTR_W = $clog2(CELL_WORDS);

   logic             wr_en;
   logic             full;
   logic             ovf;
   logic [PTR_W-1:0] ptr;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] rd_q;

   cmb_ctrl #(
      .CELL_WORDS (CELL_WORDS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .full      (full),
      .ovf       (ovf),
      .ptr       (ptr)
   );

   cmb_store #(
      .WORD_W     (WORD_W),
      .CELL_WORDS (CELL_WORDS),
      .TAG_WORD   (TAG_WORD),
      .TAG_BIT    (TAG_BIT)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .upstream (cap_upstream),
      .cell_in  (cap_cell),
      .rd_idx   (ptr),
      .word_out (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en)
         rd_q <= full ? word : '0;
   end

   assign rd_data    = rd_q;
   assign irq_cell   = full;
   assign ovf_sticky = ovf;

   // R6
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !irq_cell) |=> rd_data == '0);
endmodule

// File: tb/cell_rx_mailbox_test.sv
`timescale 1ns/1ps
module cell_rx_mailbox_test;
   localparam int W = 16;
   localparam int N = 27;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cap_valid = 1'b0;
   logic           cap_upstream = 1'b0;
   logic [W*N-1:0] cap_cell = '0;
   logic           rd_en = 1'b0;
   logic [W-1:0]   rd_data;
   logic           irq_cell;
   logic           ovf_sticky;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cell_rx_mailbox uut (
      .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_upstream(cap_upstream),
      .cap_cell(cap_cell), .rd_en(rd_en), .rd_data(rd_data),
      .irq_cell(irq_cell), .ovf_sticky(ovf_sticky)
   );

   // stimulus table: {upstream, seed}
   localparam logic [16:0] VEC [0:4] = '{
      {1'b0, 16'h1A2B}, {1'b1, 16'h0000}, {1'b1, 16'hFFFF},
      {1'b0, 16'h5A5A}, {1'b1, 16'h00C3}
   };

   function automatic logic [W-1:0] raw_word(logic [15:0] seed, int k);
      return seed ^ (16'(k) * 16'h1357) ^ 16'h0040;
   endfunction

   function automatic logic [W-1:0] exp_word(logic [15:0] seed, int k, logic up);
      logic [W-1:0] w = raw_word(seed, k);
      if (k == 2) w[6] = up;   // R4: word 2, bit 6 carries direction
      return w;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; cap_valid = 1'b0; rd_en = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic capture(logic [15:0] seed, logic up);
      for (int k = 0; k < N; k++) cap_cell[k*W +: W] = raw_word(seed, k);
      cap_upstream = up;
      cap_valid = 1'b1;
      @(negedge clk);
      cap_valid = 1'b0;
   endtask

   task automatic read_one(output logic [W-1:0] v);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      do_reset();
      // R1 reset state
      chk("R1 irq", 16'(irq_cell), 16'h0);
      chk("R1 ovf", 16'(ovf_sticky), 16'h0);
      chk("R1 rd_data", rd_data, 16'h0);

      // table walk: R2, R3, R4, R5, R9
      foreach (VEC[i]) begin
         capture(VEC[i][15:0], VEC[i][16]);
         chk("R2 irq set", 16'(irq_cell), 16'h1);
         for (int k = 0; k < N; k++) begin
            read_one(v);
            chk((k == 2) ? "R4 tag word" : "R3 word order", v, exp_word(VEC[i][15:0], k, VEC[i][16]));
            chk("R5 irq", 16'(irq_cell), (k == N - 1) ? 16'h0 : 16'h1);
         end
         chk("R9 no ovf", 16'(ovf_sticky), 16'h0);
      end

      // R6 reads while empty
      for (int k = 0; k < 3; k++) begin
         read_one(v);
         chk("R6 empty read zero", v, 16'h0);
      end
      capture(16'h3C3C, 1'b0);
      read_one(v);
      chk("R6 pointer held", v, exp_word(16'h3C3C, 0, 1'b0));
      for (int k = 1; k < N; k++) read_one(v);
      chk("R6 drained", 16'(irq_cell), 16'h0);

      // R7 drop while full
      capture(16'h1111, 1'b1);
      capture(16'h2222, 1'b0);
      chk("R7 ovf set", 16'(ovf_sticky), 16'h1);
      chk("R7 still full", 16'(irq_cell), 16'h1);
      for (int k = 0; k < N; k++) begin
         read_one(v);
         chk("R7 content kept", v, exp_word(16'h1111, k, 1'b1));
      end
      capture(16'h4444, 1'b0);
      chk("R7 ovf sticky", 16'(ovf_sticky), 16'h1);
      for (int k = 0; k < N; k++) read_one(v);

      // R8 capture on the 27th read
      do_reset();
      chk("R1 ovf after reset", 16'(ovf_sticky), 16'h0);
      capture(16'h7777, 1'b1);
      for (int k = 0; k < N - 1; k++) read_one(v);
      for (int k = 0; k < N; k++) cap_cell[k*W +: W] = raw_word(16'h8888, k);
      cap_valid = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      cap_valid = 1'b0; rd_en = 1'b0;
      chk("R8 last word", rd_data, exp_word(16'h7777, N - 1, 1'b1));
      chk("R8 empty", 16'(irq_cell), 16'h0);
      chk("R8 ovf", 16'(ovf_sticky), 16'h1);
      read_one(v);
      chk("R8 nothing stored", v, 16'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule